// File: doc/BRIEF.md
# Gapped Channel Clock Generator

This block drives a per-timeslot gated clock for a framed serial backplane. A free-running bit counter follows the backplane bit clock and is realigned by a frame-sync pulse. A 32-bit channel mask decides, for every bit time, whether a clock pulse is let through. The mask is held in four byte-wide select registers that are written through a simple write port. Downstream logic uses the gapped clock to capture only the timeslots it owns.

The block supports two frame formats. The wide format has 32 channels of 8 bits each, 256 bit times per frame. The narrow format has a single framing bit followed by 24 channels of 8 bits, 193 bit times per frame. In the narrow format, the lowest bit of the fourth select register controls a pulse during the framing bit. Its other seven bits are ignored.

Register writes land in a shadow copy and are applied only at the next frame boundary, so a frame is never gated by a half-updated mask. The output pulse is a registered enable combined with the low phase of the bit clock, so it cannot glitch.

Top module: `gapclk_gen`

## Requirements
- R1: While and after reset, `chclk_en` and `chclk` are 0 and all four select registers read as zero, so no pulses appear until a mask is written.
- R2: Select register index i (0..3), bit b (0..7) enables channel 8·i+b+1. Bit 0 is the lowest channel of each register.
- R3: With `mode_24ch`=0, a frame is 256 bit times and bit time t (0..255) is pulsed exactly when channel t/8+1 (integer division) is enabled.
- R4: With `mode_24ch`=1, bit time 0 is the framing bit and is pulsed exactly when register index 3 bit 0 is 1.
- R5: With `mode_24ch`=1, a frame is 193 bit times and bit time t (1..192) is pulsed exactly when channel (t−1)/8+1 is enabled.
- R6: With `mode_24ch`=1, bits 1 to 7 of register index 3 have no effect on any bit time.
- R7: A `fsync` high at a rising clock edge makes the bit time that starts at that edge bit 0 of a frame.
- R8: Without `fsync`, the bit counter wraps to bit 0 after the last bit time of the frame in the selected mode.
- R9: A register write becomes visible in the gating only from the next frame start (wrap or sync). The remainder of the current frame uses the previous mask.
- R10: `chclk` equals `chclk_en` while the clock is low and is 0 while the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane bit clock, one bit time per period |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse; the next bit time is bit 0 |
| mode_24ch | input | 1 | 0 = 32-channel 256-bit frame, 1 = framing bit plus 24 channels |
| wr_en | input | 1 | Select-register write strobe |
| wr_idx | input | 2 | Select register index 0..3 |
| wr_data | input | 8 | Byte written to the indexed select register |
| chclk_en | output | 1 | Registered per-bit-time pulse enable |
| chclk | output | 1 | Gapped channel clock |

## Verification
The hardest case to reach is a write that arrives in the middle of a frame. The bench has to show that the old mask still governs every remaining bit time and that the new one takes over exactly at the wrap. To get there, the bench issues a write at a known bit position partway through a fully checked frame. It then sweeps the rest of that frame and the whole next frame bit by bit. Each mode is also swept in full, with masks that fill or clear the fourth register only in its upper bits. A sync is forced mid-frame to show realignment.

// File: rtl/gapclk_pkg.sv
package gapclk_pkg;

   typedef enum logic {
      BP_WIDE   = 1'b0,
      BP_NARROW = 1'b1
   } bp_mode_e;

   // bit times in one frame for a channel count, slot width and framing-bit flag
   function automatic int frame_bits(input int chans, input int slot, input bit has_fbit);
      return chans * slot + (has_fbit ? 1 : 0);
   endfunction

endpackage

// File: rtl/gapclk_regbank.sv
module gapclk_regbank #(
   parameter int REG_W    = 8,
   parameter int NUM_REGS = 4,
   parameter int IDX_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [REG_W-1:0]          wr_data,
   input  logic                      commit,
   output logic [NUM_REGS*REG_W-1:0] shadow,
   output logic [NUM_REGS*REG_W-1:0] active
);

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [REG_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
               q <= wr_data;
            end
         end
         assign shadow[r*REG_W +: REG_W] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= '0;
      end else if (commit) begin
         active <= shadow;
      end
   end

   // written byte reaches the shadow copy one edge later
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == '0) |=> (shadow[REG_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/gapclk_bitcnt.sv
module gapclk_bitcnt #(
   parameter int CNT_W     = 8,
   parameter int LEN_WIDE  = 256,
   parameter int LEN_NARROW = 193
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             mode_narrow,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             frame_start
);

   localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(LEN_WIDE - 1);
   localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(LEN_NARROW - 1);

   logic [CNT_W-1:0] last_bit;

   assign last_bit    = mode_narrow ? LAST_NARROW : LAST_WIDE;
   // >= also catches a count left beyond the end after a mode change
   assign cnt_nxt     = (fsync || (cnt >= last_bit)) ? '0 : cnt + CNT_W'(1);
   assign frame_start = (cnt_nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_nxt;
      end
   end

   p_sync_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (cnt == '0));

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync && cnt < last_bit) |=> (cnt == $past(cnt) + CNT_W'(1)));

   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync && cnt == last_bit) |=> (cnt == '0));

endmodule

// File: rtl/gapclk_slotsel.sv
module gapclk_slotsel #(
   parameter int CH_MAX    = 32,
   parameter int CH_ALT    = 24,
   parameter int SLOT_BITS = 8,
   parameter int CNT_W     = 8
) (
   input  logic [CNT_W-1:0]  pos,
   input  logic              mode_narrow,
   input  logic [CH_MAX-1:0] mask,
   output logic              sel
);

   logic [CNT_W-1:0] rel;
   logic [CNT_W-1:0] ch;
   logic             hit;

   // in the narrow frame the payload starts one bit later
   assign rel = mode_narrow ? (pos - CNT_W'(1)) : pos;

   generate
      if ((SLOT_BITS & (SLOT_BITS - 1)) == 0) begin : g_shift
         localparam int SH = $clog2(SLOT_BITS);
         assign ch = rel >> SH;
      end else begin : g_divide
         assign ch = CNT_W'(rel / CNT_W'(SLOT_BITS));
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < CH_MAX; i++) begin
         if ((ch == CNT_W'(i)) && (!mode_narrow || (i < CH_ALT))) begin
            hit = mask[i];
         end
      end
   end

   // framing bit borrows the mask bit just above the last narrow channel
   assign sel = (mode_narrow && (pos == '0)) ? mask[CH_ALT] : hit;

endmodule

// File: rtl/gapclk_gen.sv
module gapclk_gen #(
   parameter int CH_MAX      = 32,
   parameter int CH_ALT      = 24,
   parameter int SLOT_BITS   = 8,
   parameter int REG_W       = 8,
   parameter int IDX_W       = 2,
   parameter bit GATE_ON_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             mode_24ch,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_data,
   output logic             chclk_en,
   output logic             chclk
);

   import gapclk_pkg::*;

   localparam int NUM_REGS   = CH_MAX / REG_W;
   localparam int LEN_WIDE   = frame_bits(CH_MAX, SLOT_BITS, 1'b0);
   localparam int LEN_NARROW = frame_bits(CH_ALT, SLOT_BITS, 1'b1);
   localparam int CNT_W      = $clog2(LEN_WIDE);

   generate
      if (CH_MAX % REG_W != 0) begin : g_bad_regw
         $error("CH_MAX must be a multiple of REG_W");
      end
      if (NUM_REGS < 2 || $clog2(NUM_REGS) != IDX_W) begin : g_bad_idx
         $error("IDX_W must index exactly CH_MAX/REG_W registers");
      end
      if (CH_ALT >= CH_MAX) begin : g_bad_alt
         $error("CH_ALT must leave a mask bit for the framing bit");
      end
      if (LEN_NARROW > LEN_WIDE) begin : g_bad_len
         $error("narrow frame must not exceed the wide frame");
      end
   endgenerate

   bp_mode_e                   mode;
   logic                       mode_narrow;
   logic [CNT_W-1:0]           cnt;
   logic [CNT_W-1:0]           cnt_nxt;
   logic                       frame_start;
   logic [NUM_REGS*REG_W-1:0]  shadow;
   logic [NUM_REGS*REG_W-1:0]  active;
   logic [CH_MAX-1:0]          mask_nxt;
   logic                       sel_nxt;

   assign mode        = bp_mode_e'(mode_24ch);
   assign mode_narrow = (mode == BP_NARROW);

   gapclk_bitcnt #(
      .CNT_W      (CNT_W),
      .LEN_WIDE   (LEN_WIDE),
      .LEN_NARROW (LEN_NARROW)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsync       (fsync),
      .mode_narrow (mode_narrow),
      .cnt         (cnt),
      .cnt_nxt     (cnt_nxt),
      .frame_start (frame_start)
   );

   gapclk_regbank #(
      .REG_W    (REG_W),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .commit  (frame_start),
      .shadow  (shadow),
      .active  (active)
   );

   // the first bit of a new frame is gated by the mask being committed
   assign mask_nxt = frame_start ? shadow : active;

   gapclk_slotsel #(
      .CH_MAX    (CH_MAX),
      .CH_ALT    (CH_ALT),
      .SLOT_BITS (SLOT_BITS),
      .CNT_W     (CNT_W)
   ) u_sel (
      .pos         (cnt_nxt),
      .mode_narrow (mode_narrow),
      .mask        (mask_nxt),
      .sel         (sel_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chclk_en <= 1'b0;
      end else begin
         chclk_en <= sel_nxt;
      end
   end

   generate
      if (GATE_ON_LOW) begin : g_low
         assign chclk = chclk_en & ~clk;
         always_comb begin
            if (rst_n) begin
               p_no_high_pulse_r10: assert (!(chclk && clk));
            end
         end
      end else begin : g_high
         assign chclk = chclk_en & clk;
      end
   endgenerate

   p_commit_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active) |-> (cnt == '0));

   p_dark_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (active == '0 && shadow == '0) |=> !chclk_en);

endmodule

// File: tb/gapclk_gen_bench.sv
`timescale 1ns/1ps
module gapclk_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       mode_24ch = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic       chclk_en;
   logic       chclk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gapclk_gen u_gapclk_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsync     (fsync),
      .mode_24ch (mode_24ch),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .chclk_en  (chclk_en),
      .chclk     (chclk)
   );

   function automatic bit exp_bit(input bit m24, input logic [31:0] mk, input int t);
      if (!m24) return mk[t / 8];
      if (t == 0) return mk[24];
      return mk[(t - 1) / 8];
   endfunction

   task automatic check(input bit got, input bit exp, input string req, input int t);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s bit %0d: got %0b expected %0b", req, t, got, exp);
      end
   endtask

   task automatic wr_mask(input logic [31:0] m);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = 2'(i); wr_data = m[8*i +: 8];
         @(posedge clk); #1;
         wr_en = 1'b0;
      end
   endtask

   task automatic sync_pulse(input bit m24);
      @(negedge clk);
      mode_24ch = m24; fsync = 1'b1;
      @(posedge clk); #1;
      fsync = 1'b0;
   endtask

   // sweep one frame from bit 0; optional write at bit wpos
   task automatic sweep(input bit m24, input logic [31:0] mk, input string req,
                        input int wpos, input logic [1:0] widx, input logic [7:0] wdat);
      int len = m24 ? 193 : 256;
      for (int t = 0; t < len; t++) begin
         @(negedge clk); #0.5;
         check(chclk_en, exp_bit(m24, mk, t), req, t);
         check(chclk, chclk_en, "R10 low phase", t);
         if (t == wpos) begin
            wr_en = 1'b1; wr_idx = widx; wr_data = wdat;
         end
         @(posedge clk); #1;
         wr_en = 1'b0;
         check(chclk, 1'b0, "R10 high phase", t);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(chclk_en, 1'b0, "R1 reset enable", 0);
      check(chclk, 1'b0, "R1 reset clock", 0);
      @(negedge clk); rst_n = 1'b1;
      sync_pulse(1'b0);
      sweep(1'b0, 32'h0, "R1 empty mask", -1, 2'd0, 8'h0);

      // R3/R2 wide frame, then R8 free-running wrap
      wr_mask(32'hA5C3_0F81);
      sync_pulse(1'b0);
      sweep(1'b0, 32'hA5C3_0F81, "R3 wide pattern", -1, 2'd0, 8'h0);
      sweep(1'b0, 32'hA5C3_0F81, "R8 wide wrap", -1, 2'd0, 8'h0);

      // R2 edge channels 1 and 32
      wr_mask(32'h8000_0001);
      sync_pulse(1'b0);
      sweep(1'b0, 32'h8000_0001, "R2 edge channels", -1, 2'd0, 8'h0);
      wr_mask(32'hFFFF_FFFF);
      sync_pulse(1'b0);
      sweep(1'b0, 32'hFFFF_FFFF, "R3 all channels", -1, 2'd0, 8'h0);

      // R4/R5 narrow frame with framing pulse, R8 wrap at 193
      wr_mask(32'h015A_C33C);
      sync_pulse(1'b1);
      sweep(1'b1, 32'h015A_C33C, "R5 R4 narrow pattern", -1, 2'd0, 8'h0);
      sweep(1'b1, 32'h015A_C33C, "R8 narrow wrap", -1, 2'd0, 8'h0);

      // R6 upper bits of register 3 ignored, framing bit off
      wr_mask(32'hFEA5_5AA5);
      sync_pulse(1'b1);
      sweep(1'b1, 32'hFEA5_5AA5, "R6 upper bits ignored", -1, 2'd0, 8'h0);
      wr_mask(32'hFF00_0000);
      sync_pulse(1'b1);
      sweep(1'b1, 32'hFF00_0000, "R6 R4 framing only", -1, 2'd0, 8'h0);

      // R7 sync in mid-frame realigns
      wr_mask(32'h0000_FF00);
      sync_pulse(1'b0);
      repeat (37) @(posedge clk);
      sync_pulse(1'b0);
      sweep(1'b0, 32'h0000_FF00, "R7 mid-frame sync", -1, 2'd0, 8'h0);

      // R9 mid-frame write held until the wrap
      wr_mask(32'h0000_00FF);
      sync_pulse(1'b0);
      sweep(1'b0, 32'h0000_00FF, "R9 old mask holds", 5, 2'd1, 8'hFF);
      sweep(1'b0, 32'h0000_FFFF, "R9 new mask at wrap", -1, 2'd0, 8'h0);

      finish_run();
   end

endmodule